// File: doc/BRIEF.md
# Carry-Save Montgomery Modular Exponentiator

The block computes M^E mod N for an odd modulus N of a parameterised width W. The width is 1024 in the target configuration, and 32 is the default used for simulation. A single Montgomery product engine does all the work. It takes one multiplier bit per cycle and keeps its running sum as a pair of sum and carry vectors. Each iteration passes through two levels of carry-save adders. The first level adds the selected multiplicand. The second level adds the modulus when the partial sum is odd. The engine then halves the pair, so no carry ever ripples across the word inside the loop.

A controller steps through the exponent from its most significant bit downwards. It first skips the leading zero bits. It brings M into the Montgomery domain by multiplying it with R^2 mod N, where R = 2^(W+2). The caller computes this constant and supplies it. For each later exponent bit the controller squares the running value, and if the bit is set it also multiplies by the domain form of M. It leaves the domain by multiplying by 1. The running value stays in carry-save form between products. The multiplier operand is converted bit by bit through a one-bit serial adder while it is being scanned. A full-width addition is therefore needed only where a squaring needs a binary multiplicand, and once more for the final result.

A caller places M, E, N and R^2 mod N on the inputs and pulses `start_i`. The result is valid in the cycle in which `done_o` pulses. It then stays unchanged until the next run finishes.

Top module: `csa_modexp`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: For an odd N of at least 3, M < N and `r2_i` = 2^(2W+4) mod N, the run ends with `result_o` = M^E mod N, presented in the cycle `done_o` is 1.
- R3: An all-zero exponent yields `result_o` = 1.
- R4: Leading zero exponent bits cost one cycle each and no product. With E = 1 the result is M, and `done_o` rises on the (3W+12)-th rising edge, counting the edge that samples `start_i` as the first.
- R5: The result is fully reduced and is always below N. M = N-1 with an odd E gives N-1, and M = 0 with a nonzero E gives 0.
- R6: A `start_i` pulse that arrives while a run is in progress is ignored. The ongoing run keeps its operands, and only one `done_o` pulse follows.
- R7: `done_o` is high for exactly one cycle per run, and `result_o` holds its value in every cycle in which `done_o` is low.
- R8: With E = 0, `done_o` rises on the (2W+7)-th rising edge, counting from the edge that samples `start_i`. For any E the run finishes within 2W(W+6)+16 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a run; operands are sampled in the same cycle |
| m_i | input | W | Base M, below N |
| e_i | input | W | Exponent E |
| n_i | input | W | Odd modulus N, at least 3 |
| r2_i | input | W | Domain-entry constant 2^(2W+4) mod N |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| result_o | output | W | M^E mod N, held until the next run completes |

## Verification
Each Montgomery product takes W+3 cycles from its launch to its done pulse. The controller consumes the product two cycles later, so one product step costs W+5 edges. This makes the full latency exact for the directed cases: 2W+7 edges for E = 0 and 3W+12 for E = 1. For random exponents it is bounded by 2W(W+6)+16. The bench counts rising edges from the edge that samples `start_i`. It samples only on falling edges, and compares the latency when the result pulse is seen. Right after each result, the monitor checks in the next cycle that the pulse has dropped. Two cycles later it checks that the value is still held. When a second start arrives during a run, any extra result pulse is caught because its scoreboard queue is empty.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
    // Exponent controller states
    typedef enum logic [2:0] {
        C_IDLE,
        C_ENTER,
        C_SKIP,
        C_NEXT,
        C_SQ,
        C_MUL,
        C_EXIT
    } ctl_st_e;

    // Product engine phases
    typedef enum logic [1:0] {
        E_IDLE,
        E_PRIME,
        E_RUN
    } eng_ph_e;
endpackage

// File: rtl/mexp_csa.sv
// One row of full adders: a + b + c = sum + 2*cout, bitwise.
module mexp_csa #(
    parameter int WID = 36
) (
    input  logic [WID-1:0] a_i,
    input  logic [WID-1:0] b_i,
    input  logic [WID-1:0] c_i,
    output logic [WID-1:0] sum_o,
    output logic [WID-1:0] cout_o
);
    for (genvar j = 0; j < WID; j++) begin : g_fa
        assign sum_o[j]  = a_i[j] ^ b_i[j] ^ c_i[j];
        assign cout_o[j] = (a_i[j] & b_i[j]) | (a_i[j] & c_i[j]) | (b_i[j] & c_i[j]);
    end
endmodule

// File: rtl/mexp_mont_core.sv
// Bit-serial Montgomery product, carry-save accumulator, R = 2^(W+2).
// Multiplier arrives as a sum/carry pair and is converted bit-serially.
module mexp_mont_core
    import mexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [W+3:0]      xs_i,
    input  logic [W+3:0]      xc_i,
    input  logic [W+3:0]      y_i,
    input  logic [W+3:0]      n_i,
    output logic              done_o,
    output logic [W+3:0]      sum_o,
    output logic [W+3:0]      cry_o
);
    localparam int WS    = W + 4;
    localparam int ITERS = W + 2;
    localparam int CW    = $clog2(ITERS) + 1;

    typedef struct packed {
        eng_ph_e       ph;
        logic [WS-1:0] xs;
        logic [WS-1:0] xc;
        logic [WS-1:0] y;
        logic [WS-1:0] n;
        logic          cy;
        logic [WS-1:0] yb;
        logic [WS-1:0] s;
        logic [WS-1:0] c;
        logic [CW-1:0] cnt;
        logic          done;
    } eng_t;

    eng_t q, d;

    logic          a_bit, cy_next;
    logic [WS-1:0] s1, c1, s2, c2, qn;
    logic          qbit;

    // serial conversion of the carry-save multiplier
    assign a_bit   = q.xs[0] ^ q.xc[0] ^ q.cy;
    assign cy_next = (q.xs[0] & q.xc[0]) | (q.xs[0] & q.cy) | (q.xc[0] & q.cy);

    // level one: S + C + registered a*Y
    mexp_csa #(.WID(WS)) u_lvl1 (
        .a_i(q.s), .b_i(q.c), .c_i(q.yb), .sum_o(s1), .cout_o(c1)
    );

    assign qbit = s1[0];
    assign qn   = qbit ? q.n : '0;

    // level two: + q*N
    mexp_csa #(.WID(WS)) u_lvl2 (
        .a_i(s1), .b_i({c1[WS-2:0], 1'b0}), .c_i(qn), .sum_o(s2), .cout_o(c2)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.ph)
            E_IDLE: begin
                if (go_i) begin
                    d.xs = xs_i;
                    d.xc = xc_i;
                    d.y  = y_i;
                    d.n  = n_i;
                    d.cy = 1'b0;
                    d.s  = '0;
                    d.c  = '0;
                    d.ph = E_PRIME;
                end
            end
            E_PRIME: begin
                d.yb  = a_bit ? q.y : '0;
                d.cy  = cy_next;
                d.xs  = q.xs >> 1;
                d.xc  = q.xc >> 1;
                d.cnt = '0;
                d.ph  = E_RUN;
            end
            E_RUN: begin
                d.s   = s2 >> 1;
                d.c   = c2;
                d.yb  = a_bit ? q.y : '0;
                d.cy  = cy_next;
                d.xs  = q.xs >> 1;
                d.xc  = q.xc >> 1;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(ITERS - 1)) begin
                    d.ph   = E_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.ph = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign sum_o  = q.s;
    assign cry_o  = q.c;

    // R2: the odd-modulus correction leaves an even value before the halving
    assert_even_before_halve_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == E_RUN) |-> (s2[0] == 1'b0));

    // R2: exactly W+2 iterations per product
    assert_iter_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == E_RUN) |-> (q.cnt <= CW'(ITERS - 1)));

    // R7: engine completion is a single-cycle event
    assert_core_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: rtl/csa_modexp.sv
// Left-to-right square-and-multiply controller around the product engine.
module csa_modexp
    import mexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] m_i,
    input  logic [W-1:0] e_i,
    input  logic [W-1:0] n_i,
    input  logic [W-1:0] r2_i,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    localparam int WS = W + 4;
    localparam int LW = $clog2(W + 1);

    typedef struct packed {
        ctl_st_e       st;
        logic [W-1:0]  e;
        logic [LW-1:0] left;
        logic [W-1:0]  n;
        logic [WS-1:0] mt;
        logic [WS-1:0] ts;
        logic [WS-1:0] tc;
        logic          mulp;
        logic          go;
        logic [WS-1:0] gxs;
        logic [WS-1:0] gxc;
        logic [WS-1:0] gy;
        logic [W-1:0]  res;
        logic          done;
    } ctl_t;

    ctl_t q, d;

    logic          eng_done;
    logic [WS-1:0] eng_s, eng_c, res_v, n_ext;

    assign n_ext = WS'(q.n);
    assign res_v = eng_s + eng_c;

    mexp_mont_core #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (q.go),
        .xs_i   (q.gxs),
        .xc_i   (q.gxc),
        .y_i    (q.gy),
        .n_i    (n_ext),
        .done_o (eng_done),
        .sum_o  (eng_s),
        .cry_o  (eng_c)
    );

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        case (q.st)
            C_IDLE: begin
                if (start_i) begin
                    d.n    = n_i;
                    d.e    = e_i;
                    d.left = LW'(W);
                    d.go   = 1'b1;
                    d.gxs  = WS'(m_i);
                    d.gxc  = '0;
                    d.gy   = WS'(r2_i);
                    d.st   = C_ENTER;
                end
            end
            C_ENTER: begin
                if (eng_done) begin
                    d.mt = res_v;
                    d.st = C_SKIP;
                end
            end
            C_SKIP: begin
                if (q.left == '0) begin
                    d.res  = W'(1);
                    d.done = 1'b1;
                    d.st   = C_IDLE;
                end else begin
                    d.e    = q.e << 1;
                    d.left = q.left - 1'b1;
                    if (q.e[W-1]) begin
                        d.ts = q.mt;
                        d.tc = '0;
                        d.st = C_NEXT;
                    end
                end
            end
            C_NEXT: begin
                d.go  = 1'b1;
                d.gxs = q.ts;
                d.gxc = q.tc;
                if (q.left == '0) begin
                    d.gy = WS'(1);
                    d.st = C_EXIT;
                end else begin
                    d.mulp = q.e[W-1];
                    d.e    = q.e << 1;
                    d.left = q.left - 1'b1;
                    d.gy   = q.ts + q.tc;
                    d.st   = C_SQ;
                end
            end
            C_SQ: begin
                if (eng_done) begin
                    d.ts = eng_s;
                    d.tc = eng_c;
                    if (q.mulp) begin
                        d.go  = 1'b1;
                        d.gxs = eng_s;
                        d.gxc = eng_c;
                        d.gy  = q.mt;
                        d.st  = C_MUL;
                    end else begin
                        d.st = C_NEXT;
                    end
                end
            end
            C_MUL: begin
                if (eng_done) begin
                    d.ts = eng_s;
                    d.tc = eng_c;
                    d.st = C_NEXT;
                end
            end
            C_EXIT: begin
                if (eng_done) begin
                    d.res  = (res_v >= n_ext) ? W'(res_v - n_ext) : W'(res_v);
                    d.done = 1'b1;
                    d.st   = C_IDLE;
                end
            end
            default: d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o   = q.done;
    assign result_o = q.res;

    // R5: a delivered result is fully reduced
    assert_result_below_n_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o < q.n));

    // R6: a start during a run leaves the latched modulus untouched
    assert_ignore_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st != C_IDLE) && start_i) |=> $stable(q.n));

    // R7: single-cycle completion pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: the result only moves together with the pulse
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
endmodule

// File: tb/csa_modexp_tb_top.sv
module csa_modexp_tb_top;
    localparam int W = 32;
    localparam int LAT_E0  = 2 * W + 7;
    localparam int LAT_E1  = 3 * W + 12;
    localparam int LAT_MAX = 2 * W * (W + 6) + 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] m_i = '0, e_i = '0, n_i = '0, r2_i = '0;
    logic         done_o;
    logic [W-1:0] result_o;

    always #4 clk = ~clk; // 125 MHz

    csa_modexp #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .m_i(m_i), .e_i(e_i), .n_i(n_i), .r2_i(r2_i),
        .done_o(done_o), .result_o(result_o)
    );

    typedef struct {
        logic [W-1:0] exp_res;
        int           lat_exp;   // 0: bound check only
        int           req;
    } item_t;

    item_t sb_q[$];
    int nchk = 0, nbad = 0;
    int issued = 0, seen = 0;
    longint cyc = 0;
    longint t_start = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint unsigned ref_pow(longint unsigned m, longint unsigned e,
                                                longint unsigned n);
        longint unsigned r = 1 % n;
        longint unsigned b = m % n;
        for (int i = 0; i < W; i++) begin
            if (e[i]) r = (r * b) % n;
            b = (b * b) % n;
        end
        return r;
    endfunction

    function automatic longint unsigned ref_r2(longint unsigned n);
        longint unsigned r = 1;
        for (int i = 0; i < 2 * (W + 2); i++) r = (r << 1) % n;
        return r;
    endfunction

    // Driver: push the expectation, pulse start, wait for the monitor
    task automatic run(input logic [W-1:0] m, input logic [W-1:0] e, input logic [W-1:0] n,
                       input int lat, input int req);
        item_t it;
        it.exp_res = W'(ref_pow(m, e, n));
        it.lat_exp = lat;
        it.req     = req;
        sb_q.push_back(it);
        issued++;
        @(negedge clk);
        m_i = m; e_i = e; n_i = n; r2_i = W'(ref_r2(n));
        start_i = 1'b1;
        t_start = cyc;
        @(negedge clk);
        start_i = 1'b0;
        while (seen < issued) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pop and compare on each completion pulse
    initial begin
        forever begin
            @(negedge clk);
            if (done_o) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected done", 1, 0);
                end else begin
                    item_t it;
                    logic [W-1:0] held;
                    longint lat;
                    it  = sb_q.pop_front();
                    lat = cyc - t_start;
                    chk(result_o == it.exp_res, $sformatf("R%0d result", it.req),
                        result_o, it.exp_res);
                    if (it.lat_exp != 0)
                        chk(lat == it.lat_exp, $sformatf("R%0d latency", it.req), lat, it.lat_exp);
                    else
                        chk(lat <= LAT_MAX, "R8 latency bound", lat, LAT_MAX);
                    held = result_o;
                    seen++;
                    @(negedge clk);
                    chk(done_o == 1'b0, "R7 pulse width", done_o, 0);
                    @(negedge clk);
                    chk(result_o == held, "R7 hold", result_o, held);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done_o == 1'b0, "R1 done", done_o, 0);
        chk(result_o == '0, "R1 result", result_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 / R8: zero exponent, exact latency
        run(32'd5, 32'd0, 32'd13, LAT_E0, 3);
        run(32'h1234_5677, 32'd0, 32'hF000_0001, LAT_E0, 8);
        // R4: single set bit at the bottom, exact latency
        run(32'd12345, 32'd1, 32'hFFFF_FFF1, LAT_E1, 4);
        // R2: small directed case and full-width exponents
        run(32'd5, 32'd3, 32'd13, 0, 2);
        run(32'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFB, 0, 2);
        run(32'd2, 32'h8000_0000, 32'hC000_0005, 0, 2);
        // R5: boundary bases
        run(32'hFFFF_FFF0, 32'd3, 32'hFFFF_FFF1, 0, 5);
        run(32'd0, 32'd9, 32'd101, 0, 5);
        run(32'd1, 32'hDEAD_BEEF, 32'd3, 0, 5);
        // R2: random odd moduli
        for (int k = 0; k < 12; k++) begin
            logic [W-1:0] n, m, e;
            n = $urandom() | 32'h1;
            if (n < 3) n = 32'd3;
            m = $urandom() % n;
            e = $urandom();
            run(m, e, n, 0, 2);
        end

        // R6: second start during a run is ignored
        begin
            item_t it;
            it.exp_res = W'(ref_pow(32'd99, 32'hF0F0_F0F0, 32'hFFFF_FFFB));
            it.lat_exp = 0;
            it.req     = 6;
            sb_q.push_back(it);
            issued++;
            @(negedge clk);
            m_i = 32'd99; e_i = 32'hF0F0_F0F0; n_i = 32'hFFFF_FFFB;
            r2_i = W'(ref_r2(32'hFFFF_FFFB));
            start_i = 1'b1;
            t_start = cyc;
            @(negedge clk);
            start_i = 1'b0;
            repeat (30) @(negedge clk);
            m_i = 32'd4; e_i = 32'd1; n_i = 32'd7; r2_i = W'(ref_r2(32'd7));
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            while (seen < issued) @(negedge clk);
            repeat (300) @(negedge clk);
            chk(seen == issued, "R6 pulse count", seen, issued);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule